// File: doc/BRIEF.md
# I2C Client FIFO Acknowledge Controller

This block is the control core for the client (target) end of an I2C link whose data path runs through a receive FIFO and a transmit FIFO. It watches byte events from a separate bit engine and the fill state of both FIFOs. From these it decides three things. It picks the ACK or NACK answer for each byte the host writes. It asks the bus engine to hold SCL low when the FIFO on the active side cannot keep up. It raises the address-match, data-ready and FIFO threshold flags.

Address decoding and the SDA/SCL pad drivers live elsewhere. The bit engine pulses `addr_done_i` once the client's address byte has been taken. It pulses `byte_done_i` after each data byte moves across the wire. It pulses `stop_i` on a STOP condition. Four mode inputs select the acknowledge rule:
- `smart_en_i` turns on automatic acknowledge.
- `word_mode_i` groups bytes as 32-bit words.
- `len_en_i` turns on length control.
- `ack_action_i` is the programmed answer.

Length control acts only in 32-bit mode.

Top module: `i2cc_fifo_ackctl`

## Requirements
- R1: One cycle after a cycle with `addr_done_i` high, `addr_match_o` is high for exactly one cycle. The word-position and byte counters restart from zero, so the byte after an address is byte 1 of a fresh word.
- R2: While the host writes and a transfer is active, `stretch_o` follows `rx_full_i` one cycle later, whatever the mode bits are.
- R3: With `word_mode_i`=1 and `len_en_i`=0, each host-write byte whose ordinal since the address is a multiple of WORD_BYTES (4 by default) is answered with `ack_action_i`. Every other byte is ACKed. On `ack_nack_o`, 1 means NACK and 0 means ACK. On `ack_action_i`, 1 asks for NACK.
- R4: With `word_mode_i`=1 and `len_en_i`=1, only the host-write byte whose ordinal equals `len_count_i` takes `ack_action_i`. Every other byte is ACKed.
- R5: With `smart_en_i`=1 and `word_mode_i`=0, every host-write byte is ACKed (`ack_nack_o`=0), whatever `ack_action_i` is.
- R6: With `smart_en_i`=0 and `word_mode_i`=0, every host-write byte takes `ack_action_i`.
- R7: `ack_valid_o` is high for one cycle, the cycle after each `byte_done_i` of an active host write, and never for a host read.
- R8: While the host reads and a transfer is active, `stretch_o` follows `tx_empty_i` one cycle later. With 32-bit length control, this holds only until `len_count_i` bytes have been sent, after which `stretch_o` stays low.
- R9: A `byte_done_i` with `host_nack_i`=1 during a host read ends the transfer, as does `stop_i` in either direction. Two cycles later `stretch_o` and every flag are low and stay low, even with the transmit FIFO empty.
- R10: `data_ready_o` is high when a host write finds the receive FIFO full. During a host read it is high when the transmit FIFO is empty while `stretch_o` holds SCL.
- R11: During a host write, `rx_flag_o` is high when `rx_level_i` >= `rx_thresh_i` or when the 32-bit length count has been reached. During a host read, `tx_flag_o` is high when `tx_empty_i`=1 or `tx_level_i` <= `tx_thresh_i`.
- R12: With no transfer active (after reset or after its end), no stretch, acknowledge or flag output is raised, whatever the FIFO inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_done_i | input | 1 | Pulse: own address byte received |
| stop_i | input | 1 | Pulse: STOP seen on the bus |
| host_reads_i | input | 1 | Direction of this transfer, 1 = host reads; latched at address |
| smart_en_i | input | 1 | Automatic acknowledge enable |
| word_mode_i | input | 1 | 32-bit word grouping enable |
| len_en_i | input | 1 | Length control enable (word mode only) |
| len_count_i | input | LEN_W | Transfer length in bytes |
| ack_action_i | input | 1 | Programmed answer, 1 = NACK |
| byte_done_i | input | 1 | Pulse: one data byte moved on the bus |
| host_nack_i | input | 1 | Host answered the read byte with NACK (with byte_done_i) |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_thresh_i | input | LVL_W | Receive threshold |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| tx_thresh_i | input | LVL_W | Transmit threshold |
| stretch_o | output | 1 | Request to hold SCL low |
| ack_valid_o | output | 1 | Acknowledge decision valid |
| ack_nack_o | output | 1 | Acknowledge decision, 1 = NACK |
| addr_match_o | output | 1 | Address-match flag pulse |
| data_ready_o | output | 1 | Data-ready flag |
| rx_flag_o | output | 1 | Receive threshold / length flag |
| tx_flag_o | output | 1 | Transmit empty / threshold flag |

## Verification
The bench sends an address in the middle of a 32-bit word and checks that the next NACK falls on the fourth byte after it. A design that kept the old word position would NACK too early. It runs a length-controlled write of six bytes, so the programmed NACK must land on byte six and not on byte four. A design that confused the word and length rules would answer the wrong byte. It also checks that a length-controlled read releases SCL once the count is reached, even with the transmit FIFO empty, since a wrong design would hang the bus. Finally, a host NACK mid-read must drop the stretch request, and smart byte mode must ACK even when the programmed action says NACK.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;

   typedef enum logic [1:0] {
      RULE_ACK_ALL   = 2'd0,
      RULE_PROG_ALL  = 2'd1,
      RULE_PROG_WORD = 2'd2,
      RULE_PROG_LAST = 2'd3
   } ack_rule_e;

   function automatic ack_rule_e pick_rule(input logic smart, input logic word, input logic len_en);
      ack_rule_e r;
      if (word && len_en)      r = RULE_PROG_LAST;
      else if (word)           r = RULE_PROG_WORD;
      else if (smart)          r = RULE_ACK_ALL;
      else                     r = RULE_PROG_ALL;
      return r;
   endfunction

endpackage

// File: rtl/i2cc_xfer_track.sv
module i2cc_xfer_track #(
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned WORD_BYTES = 4,
   localparam int unsigned POS_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             addr_done_i,
   input  logic             stop_i,
   input  logic             host_reads_i,
   input  logic             byte_done_i,
   input  logic             host_nack_i,
   input  logic [LEN_W-1:0] len_count_i,
   output logic             active_o,
   output logic             rd_o,
   output logic [POS_W-1:0] pos_o,
   output logic             at_last_o,
   output logic             len_done_o
);

   localparam logic [LEN_W-1:0] CNT_MAX = '1;

   logic [LEN_W-1:0] cnt_q;
   logic             active_q;
   logic             rd_q;
   logic             end_xfer;

   initial begin
      assert (LEN_W >= 2) else $error("LEN_W must be at least 2");
      assert (WORD_BYTES >= 1) else $error("WORD_BYTES must be at least 1");
   end

   assign end_xfer = stop_i || (byte_done_i && active_q && rd_q && host_nack_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         rd_q     <= 1'b0;
      end else if (addr_done_i) begin
         active_q <= 1'b1;
         rd_q     <= host_reads_i;
      end else if (end_xfer) begin
         active_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   cnt_q <= '0;
      else if (addr_done_i)                          cnt_q <= '0;
      else if (byte_done_i && active_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (WORD_BYTES == 1) begin : g_no_pos
         assign pos_o = '0;
      end else begin : g_pos
         localparam logic [POS_W-1:0] POS_LAST = POS_W'(WORD_BYTES - 1);
         logic [POS_W-1:0] pos_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                        pos_q <= '0;
            else if (addr_done_i)               pos_q <= '0;
            else if (byte_done_i && active_q)   pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
         end
         assign pos_o = pos_q;
      end
   endgenerate

   logic [LEN_W:0] cnt_next;
   assign cnt_next   = {1'b0, cnt_q} + 1'b1;
   assign at_last_o  = (cnt_next == {1'b0, len_count_i});
   assign len_done_o = (cnt_q >= len_count_i);
   assign active_o   = active_q;
   assign rd_o       = rd_q;

   // R1
   pos_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_done_i |=> (pos_o == '0) && (cnt_q == '0));

   // R9
   nack_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_done_i && active_q && rd_q && host_nack_i && !addr_done_i) |=> !active_q);

endmodule

// File: rtl/i2cc_ack_policy.sv
module i2cc_ack_policy
   import i2cc_pkg::*;
#(
   parameter int unsigned WORD_BYTES = 4,
   localparam int unsigned POS_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             active_i,
   input  logic             rd_i,
   input  logic             byte_done_i,
   input  logic             smart_en_i,
   input  logic             word_mode_i,
   input  logic             len_en_i,
   input  logic             ack_action_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic             at_last_i,
   output logic             ack_valid_o,
   output logic             ack_nack_o
);

   localparam logic [POS_W-1:0] POS_LAST = POS_W'(WORD_BYTES - 1);

   ack_rule_e rule;
   logic      nack_d;
   logic      take;

   assign rule = pick_rule(smart_en_i, word_mode_i, len_en_i);
   assign take = byte_done_i && active_i && !rd_i;

   always_comb begin
      unique case (rule)
         RULE_ACK_ALL:   nack_d = 1'b0;
         RULE_PROG_ALL:  nack_d = ack_action_i;
         RULE_PROG_WORD: nack_d = (pos_i == POS_LAST) ? ack_action_i : 1'b0;
         RULE_PROG_LAST: nack_d = at_last_i ? ack_action_i : 1'b0;
         default:        nack_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ack_valid_o <= 1'b0;
         ack_nack_o  <= 1'b0;
      end else begin
         ack_valid_o <= take;
         ack_nack_o  <= take ? nack_d : 1'b0;
      end
   end

   // R3
   nack_needs_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_valid_o && ack_nack_o) |-> $past(ack_action_i));

   // R5
   smart_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_valid_o && $past(smart_en_i && !word_mode_i)) |-> !ack_nack_o);

   // R7
   no_read_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_valid_o |-> $past(byte_done_i && !rd_i));

endmodule

// File: rtl/i2cc_stretch_flags.sv
module i2cc_stretch_flags #(
   parameter int unsigned LVL_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             active_i,
   input  logic             rd_i,
   input  logic             len_ctl_i,
   input  logic             len_done_i,
   input  logic             rx_full_i,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic [LVL_W-1:0] rx_thresh_i,
   input  logic             tx_empty_i,
   input  logic [LVL_W-1:0] tx_level_i,
   input  logic [LVL_W-1:0] tx_thresh_i,
   output logic             stretch_o,
   output logic             data_ready_o,
   output logic             rx_flag_o,
   output logic             tx_flag_o
);

   logic len_reached;
   logic hold_rd;
   logic hold_wr;

   assign len_reached = len_ctl_i && len_done_i;
   assign hold_rd     = active_i && rd_i && tx_empty_i && !len_reached;
   assign hold_wr     = active_i && !rd_i && rx_full_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stretch_o    <= 1'b0;
         data_ready_o <= 1'b0;
         rx_flag_o    <= 1'b0;
         tx_flag_o    <= 1'b0;
      end else begin
         stretch_o    <= hold_rd || hold_wr;
         data_ready_o <= active_i && (rd_i ? (tx_empty_i && stretch_o) : rx_full_i);
         rx_flag_o    <= active_i && !rd_i && ((rx_level_i >= rx_thresh_i) || len_reached);
         tx_flag_o    <= active_i && rd_i && (tx_empty_i || (tx_level_i <= tx_thresh_i));
      end
   end

   // R12
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_i |=> !stretch_o && !rx_flag_o && !tx_flag_o);

   // R2
   stretch_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stretch_o && !$past(rd_i)) |-> $past(rx_full_i));

   // R8
   len_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && rd_i && len_ctl_i && len_done_i) |=> !stretch_o);

endmodule

// File: rtl/i2cc_fifo_ackctl.sv
module i2cc_fifo_ackctl
   import i2cc_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned WORD_BYTES = 4,
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             addr_done_i,
   input  logic             stop_i,
   input  logic             host_reads_i,
   input  logic             smart_en_i,
   input  logic             word_mode_i,
   input  logic             len_en_i,
   input  logic [LEN_W-1:0] len_count_i,
   input  logic             ack_action_i,
   input  logic             byte_done_i,
   input  logic             host_nack_i,
   input  logic             rx_full_i,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic [LVL_W-1:0] rx_thresh_i,
   input  logic             tx_empty_i,
   input  logic [LVL_W-1:0] tx_level_i,
   input  logic [LVL_W-1:0] tx_thresh_i,
   output logic             stretch_o,
   output logic             ack_valid_o,
   output logic             ack_nack_o,
   output logic             addr_match_o,
   output logic             data_ready_o,
   output logic             rx_flag_o,
   output logic             tx_flag_o
);

   localparam int unsigned POS_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

   initial begin
      assert (FIFO_DEPTH >= 2) else $error("FIFO_DEPTH must be at least 2");
   end

   logic             active;
   logic             rd;
   logic [POS_W-1:0] pos;
   logic             at_last;
   logic             len_done;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_match_o <= 1'b0;
      else         addr_match_o <= addr_done_i;
   end

   i2cc_xfer_track #(.LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES)) u_track (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .addr_done_i  (addr_done_i),
      .stop_i       (stop_i),
      .host_reads_i (host_reads_i),
      .byte_done_i  (byte_done_i),
      .host_nack_i  (host_nack_i),
      .len_count_i  (len_count_i),
      .active_o     (active),
      .rd_o         (rd),
      .pos_o        (pos),
      .at_last_o    (at_last),
      .len_done_o   (len_done)
   );

   i2cc_ack_policy #(.WORD_BYTES(WORD_BYTES)) u_policy (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .active_i     (active),
      .rd_i         (rd),
      .byte_done_i  (byte_done_i),
      .smart_en_i   (smart_en_i),
      .word_mode_i  (word_mode_i),
      .len_en_i     (len_en_i),
      .ack_action_i (ack_action_i),
      .pos_i        (pos),
      .at_last_i    (at_last),
      .ack_valid_o  (ack_valid_o),
      .ack_nack_o   (ack_nack_o)
   );

   i2cc_stretch_flags #(.LVL_W(LVL_W)) u_flags (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .active_i     (active),
      .rd_i         (rd),
      .len_ctl_i    (word_mode_i && len_en_i),
      .len_done_i   (len_done),
      .rx_full_i    (rx_full_i),
      .rx_level_i   (rx_level_i),
      .rx_thresh_i  (rx_thresh_i),
      .tx_empty_i   (tx_empty_i),
      .tx_level_i   (tx_level_i),
      .tx_thresh_i  (tx_thresh_i),
      .stretch_o    (stretch_o),
      .data_ready_o (data_ready_o),
      .rx_flag_o    (rx_flag_o),
      .tx_flag_o    (tx_flag_o)
   );

   // R1
   addr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_done_i |=> addr_match_o);

   // R10
   drdy_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (data_ready_o && !$past(rd)) |-> $past(rx_full_i));

endmodule

// File: tb/i2cc_fifo_ackctl_bench.sv
module i2cc_fifo_ackctl_bench;

   localparam int LEN_W = 8;
   localparam int LVL_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             addr_done = 0, stop = 0, host_reads = 0;
   logic             smart_en = 0, word_mode = 0, len_en = 0, ack_action = 0;
   logic [LEN_W-1:0] len_count = '0;
   logic             byte_done = 0, host_nack = 0;
   logic             rx_full = 0, tx_empty = 0;
   logic [LVL_W-1:0] rx_level = '0, rx_thresh = 5'd8, tx_level = 5'd10, tx_thresh = 5'd2;
   logic             stretch, ack_valid, ack_nack, addr_match, data_ready, rx_flag, tx_flag;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   i2cc_fifo_ackctl u_i2cc_fifo_ackctl (
      .clk_i(clk), .rst_ni(rst_n), .addr_done_i(addr_done), .stop_i(stop),
      .host_reads_i(host_reads), .smart_en_i(smart_en), .word_mode_i(word_mode),
      .len_en_i(len_en), .len_count_i(len_count), .ack_action_i(ack_action),
      .byte_done_i(byte_done), .host_nack_i(host_nack), .rx_full_i(rx_full),
      .rx_level_i(rx_level), .rx_thresh_i(rx_thresh), .tx_empty_i(tx_empty),
      .tx_level_i(tx_level), .tx_thresh_i(tx_thresh), .stretch_o(stretch),
      .ack_valid_o(ack_valid), .ack_nack_o(ack_nack), .addr_match_o(addr_match),
      .data_ready_o(data_ready), .rx_flag_o(rx_flag), .tx_flag_o(tx_flag)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic address(input logic rd);
      host_reads = rd; addr_done = 1;
      step(1);
      addr_done = 0;
   endtask

   // Sends one byte; returns decision seen one cycle later.
   task automatic send_byte(input logic hn, output logic v, output logic n);
      byte_done = 1; host_nack = hn;
      step(1);
      v = ack_valid; n = ack_nack;
      byte_done = 0; host_nack = 0;
   endtask

   task automatic end_xfer;
      stop = 1; step(1); stop = 0; step(2);
   endtask

   task automatic t_reset;
      check("R12 reset stretch", stretch, 0);
      check("R12 reset ack_valid", ack_valid, 0);
      check("R12 reset flags", addr_match | data_ready | rx_flag | tx_flag, 0);
      rx_full = 1; tx_empty = 1; step(2);
      check("R12 idle stretch with fifo extremes", stretch, 0);
      check("R12 idle data_ready", data_ready, 0);
      rx_full = 0; tx_empty = 0;
   endtask

   task automatic t_addr_flag;
      address(0);
      check("R1 addr_match high", addr_match, 1);
      step(1);
      check("R1 addr_match one cycle", addr_match, 0);
      end_xfer();
   endtask

   task automatic t_write_stretch;
      logic v, n;
      for (int m = 0; m < 3; m++) begin
         smart_en = (m == 1); word_mode = (m == 2); len_en = 0;
         address(0);
         rx_full = 1; step(1);
         check("R2 write stretch on full", stretch, 1);
         check("R10 data_ready write full", data_ready, 1);
         rx_full = 0; step(1);
         check("R2 write stretch released", stretch, 0);
         end_xfer();
      end
      smart_en = 0; word_mode = 0;
      address(0);
      send_byte(0, v, n);
      check("R7 write ack_valid", v, 1);
      step(1);
      check("R7 ack_valid single cycle", ack_valid, 0);
      end_xfer();
   endtask

   task automatic t_word;
      logic v, n;
      word_mode = 1; len_en = 0; ack_action = 1;
      address(0);
      for (int b = 1; b <= 8; b++) begin
         send_byte(0, v, n);
         check($sformatf("R3 word byte %0d", b), n, (b % 4 == 0));
      end
      end_xfer();
      address(0);
      send_byte(0, v, n); send_byte(0, v, n);
      address(0);
      for (int b = 1; b <= 4; b++) begin
         send_byte(0, v, n);
         check($sformatf("R1 restart pos byte %0d", b), n, (b == 4));
      end
      end_xfer();
   endtask

   task automatic t_len_write;
      logic v, n;
      word_mode = 1; len_en = 1; len_count = 8'd6; ack_action = 1; rx_level = 0;
      address(0);
      for (int b = 1; b <= 6; b++) begin
         send_byte(0, v, n);
         check($sformatf("R4 len byte %0d", b), n, (b == 6));
         if (b == 5) begin
            step(1);
            check("R11 rx_flag before length", rx_flag, 0);
         end
      end
      step(2);
      check("R11 rx_flag on length", rx_flag, 1);
      end_xfer();
      len_en = 0; word_mode = 0;
      address(0);
      rx_level = 5'd8; step(2);
      check("R11 rx_flag threshold", rx_flag, 1);
      rx_level = 5'd7; step(2);
      check("R11 rx_flag below threshold", rx_flag, 0);
      rx_level = 0;
      end_xfer();
   endtask

   task automatic t_byte_modes;
      logic v, n;
      word_mode = 0; len_en = 0; ack_action = 1; smart_en = 1;
      address(0);
      for (int b = 1; b <= 4; b++) begin
         send_byte(0, v, n);
         check("R5 smart byte ack", n, 0);
      end
      end_xfer();
      smart_en = 0;
      address(0);
      for (int b = 1; b <= 3; b++) begin
         send_byte(0, v, n);
         check("R6 plain byte takes action", n, 1);
      end
      ack_action = 0;
      send_byte(0, v, n);
      check("R6 plain byte action ack", n, 0);
      end_xfer();
   endtask

   task automatic t_read;
      logic v, n;
      smart_en = 0; word_mode = 0; len_en = 0; tx_level = 5'd10;
      address(1);
      step(2);
      check("R11 tx_flag above threshold", tx_flag, 0);
      tx_level = 5'd2; step(2);
      check("R11 tx_flag at threshold", tx_flag, 1);
      tx_level = 5'd10;
      tx_empty = 1; step(1);
      check("R8 read stretch on empty", stretch, 1);
      step(1);
      check("R10 data_ready read empty held", data_ready, 1);
      check("R11 tx_flag empty", tx_flag, 1);
      send_byte(0, v, n);
      check("R7 no ack_valid on read", v, 0);
      send_byte(1, v, n);
      step(2);
      check("R9 stretch dropped after host nack", stretch, 0);
      check("R9 flags dropped after host nack", data_ready | tx_flag, 0);
      tx_empty = 0;
      end_xfer();
      word_mode = 1; len_en = 1; len_count = 8'd2;
      address(1);
      tx_empty = 1;
      send_byte(0, v, n);
      step(1);
      check("R8 stretch before length done", stretch, 1);
      send_byte(0, v, n);
      step(1);
      check("R8 stretch released after length", stretch, 0);
      tx_empty = 0;
      end_xfer();
      word_mode = 0; len_en = 0;
      address(0);
      rx_full = 1; step(1);
      stop = 1; step(1); stop = 0; step(1);
      check("R9 stop ends stretch", stretch, 0);
      rx_full = 0;
   endtask

   initial begin
      step(3);
      rst_n = 1;
      step(1);
      t_reset();
      t_addr_flag();
      t_write_stretch();
      t_word();
      t_len_write();
      t_byte_modes();
      t_read();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule